// File: doc/BRIEF.md
# Key-Sequenced Watchdog Timer

This block is a watchdog peripheral on a 32-bit register bus. It has a 64-bit up-counter, a 64-bit timeout period that software writes as two 32-bit halves, and a small control set that places the timer in watchdog mode. Software arms the timer by writing two 16-bit key values, in order, to the key field of the watchdog control register. From the first accepted key onward, every configuration register is frozen.

Once it is armed, software keeps the system alive by repeating the same two-key handshake, and the count restarts from zero on the second key. If software stops servicing and the counter reaches the period, the block latches a timeout flag and pulses a reset-request output for one clock. The counter then starts again from zero. Only a system reset returns the block to its unlocked, disarmed state.

Writes take effect on the rising clock edge where `wr_en` is high. Reads are combinational from `addr`.

Top module: `keyed_wdog`

## Requirements
- R1: After reset, every readable register reads zero, the block is disarmed and `rst_req` is low.
- R2: While disarmed, the registers below can be written and read back. Reads and writes at any other offset, including 0x00 and 0x04, read as zero and have no effect.

  | Offset | Contents |
  |---|---|
  | 0x10 | Counter bits 31:0 |
  | 0x14 | Counter bits 63:32 |
  | 0x18 | Period bits 31:0 |
  | 0x1C | Period bits 63:32 |
  | 0x20 | Timer run-mode field in bits 7:6 |
  | 0x24 | Bit 0 and bit 1 release the low and high counter halves; bits 3:2 hold the timer mode |
  | 0x28 | Watchdog control: enable in bit 14, timeout flag in bit 15, key in bits 31:16 |

- R3: Arming takes two writes to 0x28, each with bit 14 set. Key 0xA5C6 moves the block from disarmed to pre-active, and key 0xDA7E then moves it from pre-active to active. A key write with bit 14 clear does not arm the block, and the registers stay writable.
- R4: A key write whose key is not the one the current state expects leaves the state unchanged. The pre-active state does not count.
- R5: From pre-active onward, the following writes are ignored: writes to 0x10 through 0x24, and writes to bit 14 of 0x28. The armed condition is left only through reset.
- R6: The counter advances by one per clock only when all of these hold: the block is active or waiting for the second service key, 0x24 bits 3:2 equal 2, 0x24 bits 1:0 are both 1, and 0x20 bits 7:6 are non-zero. The counter carries from the low half into the high half.
- R7: On the clock edge where the counter equals the period, three things happen. `rst_req` goes high for the following cycle, the timeout flag (0x28 bit 15) sets, and the counter restarts from zero. For a period P counted from zero, pulses are therefore spaced P+1 clocks apart.
- R8: When the block is active, key 0xA5C6 followed by key 0xDA7E restarts the count. Bit 14 is not needed for these writes. The counter is cleared only on the second key, and the first key alone does not change the timing.
- R9: Writing 1 to bit 15 of 0x28 clears the timeout flag in any state. A timeout in the same cycle wins over the clear.
- R10: If the timer mode field is not 2, an armed block neither counts nor requests reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 6 | Byte offset of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr` |
| rst_req | output | 1 | One-cycle reset request on timeout |

## Verification
The bench counts the clocks between the last accepted key write and the reset pulse. This exposes three kinds of error:
- an off-by-one in the compare;
- a counter cleared on the first service key instead of the second;
- a wrong or enable-less key that still advances the state.

It tries to rewrite the period, counter, control registers and enable bit after arming, and reads them back. A lock that leaks would show the new values or shift the timeout. A counter preset just below the 32-bit boundary catches a broken carry into the high half. A disarmed-mode configuration catches a block that counts outside watchdog mode.

// File: rtl/keyed_wdog.sv
module keyed_wdog #(
  parameter int AW = 6,
  parameter int DW = 32,
  parameter logic [15:0] KEY_A = 16'hA5C6,
  parameter logic [15:0] KEY_B = 16'hDA7E
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          rst_req
);
  localparam int CW = 2 * DW;
  localparam int EN_B = 14;
  localparam int FL_B = 15;
  localparam logic [AW-1:0] A_CLO = AW'(8'h10);
  localparam logic [AW-1:0] A_CHI = AW'(8'h14);
  localparam logic [AW-1:0] A_PLO = AW'(8'h18);
  localparam logic [AW-1:0] A_PHI = AW'(8'h1C);
  localparam logic [AW-1:0] A_RUN = AW'(8'h20);
  localparam logic [AW-1:0] A_GLB = AW'(8'h24);
  localparam logic [AW-1:0] A_WDC = AW'(8'h28);

  typedef enum logic [1:0] {S_IDLE, S_PRE, S_ACT, S_SVC} st_t;

  st_t st, st_nx;
  logic [CW-1:0] cnt, prd;
  logic [1:0] tmode, gmode, unrst;
  logic wden, tflag;

  wire [15:0] key = wdata[DW-1 -: 16];
  wire wr_ctl = wr_en && (addr == A_WDC);
  wire armed = (st != S_IDLE);
  wire wr_cfg = wr_en && !armed;
  wire svc_done = (st == S_SVC) && wr_ctl && (key == KEY_B);
  wire cnt_run = (st == S_ACT || st == S_SVC) && (gmode == 2'd2) && (&unrst) && (tmode != 2'd0);
  wire hit = cnt_run && (cnt == prd);

  always_comb begin
    st_nx = st;
    if (wr_ctl)
      case (st)
        S_IDLE: if (key == KEY_A && wdata[EN_B]) st_nx = S_PRE;
        S_PRE:  if (key == KEY_B && wdata[EN_B]) st_nx = S_ACT;
        S_ACT:  if (key == KEY_A) st_nx = S_SVC;
        default: if (key == KEY_B) st_nx = S_ACT;
      endcase
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) st <= S_IDLE;
    else        st <= st_nx;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      prd   <= '0;
      tmode <= '0;
      gmode <= '0;
      unrst <= '0;
      wden  <= 1'b0;
    end else if (wr_cfg) begin
      if (addr == A_PLO) prd[DW-1:0]  <= wdata;
      if (addr == A_PHI) prd[CW-1:DW] <= wdata;
      if (addr == A_RUN) tmode <= wdata[7:6];
      if (addr == A_GLB) begin
        gmode <= wdata[3:2];
        unrst <= wdata[1:0];
      end
      if (addr == A_WDC) wden <= wdata[EN_B];
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                          cnt <= '0;
    else if (wr_cfg && addr == A_CLO)    cnt[DW-1:0]  <= wdata;
    else if (wr_cfg && addr == A_CHI)    cnt[CW-1:DW] <= wdata;
    else if (svc_done || hit)            cnt <= '0;
    else if (cnt_run)                    cnt <= cnt + 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      tflag   <= 1'b0;
      rst_req <= 1'b0;
    end else begin
      rst_req <= hit;
      if (hit)                       tflag <= 1'b1;
      else if (wr_ctl && wdata[FL_B]) tflag <= 1'b0;
    end

  always_comb begin
    rdata = '0;
    case (addr)
      A_CLO: rdata = cnt[DW-1:0];
      A_CHI: rdata = cnt[CW-1:DW];
      A_PLO: rdata = prd[DW-1:0];
      A_PHI: rdata = prd[CW-1:DW];
      A_RUN: rdata[7:6] = tmode;
      A_GLB: rdata[3:0] = {gmode, unrst};
      A_WDC: begin
        rdata[FL_B] = tflag;
        rdata[EN_B] = wden;
      end
      default: rdata = '0;
    endcase
  end
endmodule

module wdog_chk #(
  parameter int CW = 64
) (
  input logic          clk,
  input logic          rst_n,
  input logic          armed,
  input logic          rst_req,
  input logic          tflag,
  input logic          wden,
  input logic [CW-1:0] cnt,
  input logic [CW-1:0] prd,
  input logic [5:0]    cfg
);
  // R7
  req_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n) rst_req |-> tflag);
  // R7
  req_wraps_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n) rst_req |-> cnt == '0);
  // R5
  cfg_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    armed |=> $stable(prd) && $stable(cfg) && $stable(wden));
  // R5
  arm_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n) armed |=> armed);
  // R3
  no_req_disarmed_chk: assert property (@(posedge clk) disable iff (!rst_n) !armed |-> !rst_req);
endmodule

bind keyed_wdog wdog_chk #(.CW(2 * DW)) chk_i (
  .clk(clk), .rst_n(rst_n), .armed(armed), .rst_req(rst_req), .tflag(tflag),
  .wden(wden), .cnt(cnt), .prd(prd), .cfg({tmode, gmode, unrst})
);

// File: tb/keyed_wdog_tb.sv
`timescale 1ns/1ps
module keyed_wdog_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [5:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic rst_req;
  int total = 0;
  int bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  keyed_wdog dut_i (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
                    .wdata(wdata), .rdata(rdata), .rst_req(rst_req));

  localparam int NV = 10;
  localparam logic [69:0] VEC [NV] = '{
    {6'h10, 32'h1234_5678, 32'h1234_5678},
    {6'h14, 32'h0000_00AB, 32'h0000_00AB},
    {6'h18, 32'hCAFE_0001, 32'hCAFE_0001},
    {6'h1C, 32'h0000_0002, 32'h0000_0002},
    {6'h20, 32'hFFFF_FFFF, 32'h0000_00C0},
    {6'h24, 32'hFFFF_FFFF, 32'h0000_000F},
    {6'h28, 32'h0000_4000, 32'h0000_4000},
    {6'h28, 32'h0000_0000, 32'h0000_0000},
    {6'h00, 32'hFFFF_FFFF, 32'h0000_0000},
    {6'h04, 32'hFFFF_FFFF, 32'h0000_0000}
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    wr_en = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] v);
    @(negedge clk);
    addr = a;
    #0.5 v = rdata;
  endtask

  task automatic meas(output int n);
    n = 0;
    while (!rst_req && n < 2000) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic setup(input logic [31:0] plo, input logic [31:0] phi,
                       input logic [31:0] clo, input logic [31:0] glb);
    do_reset();
    wr(6'h20, 32'h80);
    wr(6'h24, glb);
    wr(6'h10, clo);
    wr(6'h14, 32'h0);
    wr(6'h18, plo);
    wr(6'h1C, phi);
  endtask

  task automatic arm();
    wr(6'h28, 32'hA5C6_4000);
    wr(6'h28, 32'hDA7E_4000);
  endtask

  initial begin
    #1000000;
    if (!done) begin
      bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int n;
    bit seen;
    do_reset();
    // R1 reset values
    chk("R1 rst_req", rst_req, 0);
    for (int i = 0; i < 7; i++) begin
      rd(6'h10 + 6'(i * 4), v);
      chk("R1 reg", v, 0);
    end
    // R2 register table
    for (int i = 0; i < NV; i++) begin
      wr(VEC[i][69:64], VEC[i][63:32]);
      rd(VEC[i][69:64], v);
      chk("R2 readback", v, VEC[i][31:0]);
    end
    // R3 R7 arm and timeout spacing
    setup(32'd20, 32'd0, 32'd0, 32'hB);
    arm();
    meas(n);
    chk("R3 R7 first timeout", n, 21);
    rd(6'h28, v);
    chk("R7 flag set", v, 32'h0000_C000);
    chk("R7 one-cycle pulse", rst_req, 0);
    meas(n);
    chk("R7 period spacing", n, 20);
    // R9 flag clear
    wr(6'h28, 32'h0000_8000);
    rd(6'h28, v);
    chk("R9 flag clear", v, 32'h0000_4000);
    // R3 key without enable, R4 wrong key
    setup(32'd20, 32'd0, 32'd0, 32'hB);
    wr(6'h28, 32'hA5C6_0000);
    wr(6'h18, 32'd7);
    rd(6'h18, v);
    chk("R3 no-enable key ignored", v, 7);
    wr(6'h28, 32'hA5C6_4000);
    wr(6'h28, 32'h1234_4000);
    repeat (5) @(negedge clk);
    rd(6'h10, v);
    chk("R4 pre-active not counting", v, 0);
    chk("R4 no request", rst_req, 0);
    wr(6'h28, 32'hDA7E_4000);
    meas(n);
    chk("R4 arm after wrong key", n, 8);
    // R5 lock
    setup(32'd20, 32'd0, 32'd0, 32'hB);
    arm();
    wr(6'h18, 32'd3);
    wr(6'h20, 32'h0);
    wr(6'h24, 32'h0);
    wr(6'h10, 32'h100);
    wr(6'h28, 32'h0);
    rd(6'h18, v);
    chk("R5 period locked", v, 20);
    rd(6'h20, v);
    chk("R5 run mode locked", v, 32'h80);
    rd(6'h24, v);
    chk("R5 global locked", v, 32'hB);
    rd(6'h10, v);
    chk("R5 counter locked", v, 14);
    rd(6'h28, v);
    chk("R5 enable locked", v, 32'h0000_4000);
    // R8 full service
    setup(32'd20, 32'd0, 32'd0, 32'hB);
    arm();
    repeat (10) @(negedge clk);
    wr(6'h28, 32'hA5C6_0000);
    repeat (4) @(negedge clk);
    wr(6'h28, 32'hDA7E_0000);
    meas(n);
    chk("R8 service restarts", n, 21);
    // R8 first key alone, R4 wrong second key
    setup(32'd20, 32'd0, 32'd0, 32'hB);
    arm();
    repeat (5) @(negedge clk);
    wr(6'h28, 32'hA5C6_0000);
    wr(6'h28, 32'hBEEF_0000);
    meas(n);
    chk("R8 R4 no clear on partial", n, 12);
    // R6 64-bit carry
    setup(32'd5, 32'd1, 32'hFFFF_FFF0, 32'hB);
    arm();
    meas(n);
    chk("R6 carry to high half", n, 22);
    // R10 not watchdog mode
    setup(32'd5, 32'd0, 32'd0, 32'h3);
    arm();
    seen = 0;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (rst_req) seen = 1;
    end
    chk("R10 no request", seen, 0);
    rd(6'h10, v);
    chk("R10 no count", v, 0);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule